// File: doc/BRIEF.md
# Second-Level Cache Access Action Decoder

This block sits beside the lookup pipeline of a second-level cache. Each request gives it the access address, the direction, the hit or miss outcome from the tag lookup, and the bus protection attributes. From these it decides which of three actions the cache controller carries out. The first action is an access to the cache data array. The second is an access to external memory. The third is the allocation of a new line.

Cacheability begins with a fixed address window: the lower half of the address space is cacheable and the upper half is not. When the protection-attribute enable is set, the attributes can demote an access in the window to non-cacheable. They cannot promote an access that lies outside the window. For a non-cacheable access, the bufferable attribute then chooses between the action sets for strict traffic and for buffered traffic. A separate control bit sends a strict non-cacheable read hit to memory instead of the cache array.

The decision is registered. It appears together with a valid strobe one cycle after the request strobe.

Top module: `l2_access_policy`

## Requirements
- R1: With `prot_en_i` low, an access is cacheable exactly when `addr_i` is at or below 0x7FFFFFFF (bit 31 clear), and every access with bit 31 set is non-cacheable.
- R2: With `prot_en_i` low, `prot_i` has no effect on the outputs, and a non-cacheable access is handled as non-bufferable.
- R3: With `prot_en_i` high, an access is cacheable only if it lies in the window and `prot_i[3]` is 1. `prot_i[3]` = 1 never makes an access outside the window cacheable. For a non-cacheable access, `prot_i[2]` = 1 marks it bufferable.
- R4: A read hit drives the cache-array action only, except in the case named in R5.
- R5: A read hit that is non-cacheable and non-bufferable, with `rd_bypass_i` high, drives the memory action only. `rd_bypass_i` has no effect on bufferable or cacheable read hits.
- R6: A non-cacheable read miss drives the memory action only. A cacheable read miss drives allocate and memory, and not the cache array.
- R7: A write hit that is non-cacheable and non-bufferable drives both the cache-array and memory actions. Any other write hit drives the cache-array action only.
- R8: A non-cacheable write miss drives the memory action only. A cacheable write miss drives allocate only.
- R9: `vld_o` is high exactly in the cycle after a cycle with `req_i` high, and the actions then shown belong to that request. When `vld_o` is low, all three action outputs are 0.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| addr_i | input | 32 | Access address |
| wr_i | input | 1 | 1 = write, 0 = read |
| hit_i | input | 1 | Tag lookup hit |
| prot_i | input | 4 | Bus protection attributes; bit 3 cacheable, bit 2 bufferable |
| prot_en_i | input | 1 | Let the protection attributes demote cacheability |
| rd_bypass_i | input | 1 | Send strict non-cacheable read hits to memory |
| vld_o | output | 1 | Decision valid |
| use_cache_o | output | 1 | Access the cache data array |
| use_mem_o | output | 1 | Access external memory |
| alloc_o | output | 1 | Allocate a cache line |

## Verification
The bench sweeps the full cross product of four boundary addresses (0, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF), all sixteen attribute codes, direction, hit, attribute enable and bypass enable. Idle cycles are interleaved between requests.

The two addresses that straddle the window edge separate the address test from the attribute test. Repeating each vector with the attribute enable cleared shows whether the attributes are ignored. Attribute codes that differ only in the bufferable bit separate the strict action sets from the buffered ones, and toggling the bypass bit across all three classes confirms that it acts only on strict read hits.

// File: rtl/l2ap_pkg.sv
package l2ap_pkg;

  // Access class after the window and attribute checks
  typedef enum logic [1:0] {
    CLS_STRICT   = 2'd0,  // non-cacheable, non-bufferable
    CLS_BUFFERED = 2'd1,  // non-cacheable, bufferable
    CLS_CACHED   = 2'd2   // cacheable
  } cls_t;

  typedef struct packed {
    logic arr;    // cache data array access
    logic mem;    // external memory access
    logic alloc;  // line allocation
  } act_t;

  // Class from the window result and the attribute bits
  function automatic cls_t classify(logic in_win, logic en, logic cbit, logic bbit);
    logic cacheable;
    logic buffered;
    cacheable = in_win && (!en || cbit);
    buffered  = en && bbit;
    if (cacheable)     return CLS_CACHED;
    else if (buffered) return CLS_BUFFERED;
    else               return CLS_STRICT;
  endfunction

  // Action set for one access class, direction and lookup result
  function automatic act_t decide(cls_t c, logic wr, logic hit, logic byp);
    act_t a;
    a = '0;
    unique case ({wr, hit})
      2'b01: begin  // read hit
        if (c == CLS_STRICT && byp) a.mem = 1'b1;
        else                        a.arr = 1'b1;
      end
      2'b00: begin  // read miss
        a.mem = 1'b1;
        a.alloc = (c == CLS_CACHED);
      end
      2'b11: begin  // write hit
        a.arr = 1'b1;
        a.mem = (c == CLS_STRICT);
      end
      default: begin  // write miss
        a.alloc = (c == CLS_CACHED);
        a.mem   = (c != CLS_CACHED);
      end
    endcase
    return a;
  endfunction

endpackage

// File: rtl/l2ap_classify.sv
module l2ap_classify
  import l2ap_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] WIN_TOP = {1'b0, {(AW-1){1'b1}}},
  parameter int PW = 4,
  parameter int CBIT = 3,
  parameter int BBIT = 2
) (
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] prot,
  input  logic          en,
  output logic          in_win,
  output cls_t          cls
);

  always_comb begin
    in_win = (addr <= WIN_TOP);
    cls    = classify(in_win, en, prot[CBIT], prot[BBIT]);
  end

endmodule

// File: rtl/l2ap_action.sv
module l2ap_action
  import l2ap_pkg::*;
(
  input  cls_t cls,
  input  logic wr,
  input  logic hit,
  input  logic byp,
  output act_t act
);

  always_comb act = decide(cls, wr, hit, byp);

endmodule

// File: rtl/l2_access_policy.sv
module l2_access_policy
  import l2ap_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 4,
  parameter int CBIT = 3,
  parameter int BBIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          hit_i,
  input  logic [PW-1:0] prot_i,
  input  logic          prot_en_i,
  input  logic          rd_bypass_i,
  output logic          vld_o,
  output logic          use_cache_o,
  output logic          use_mem_o,
  output logic          alloc_o
);

  localparam logic [AW-1:0] WIN_TOP = {1'b0, {(AW-1){1'b1}}};

  // Named internal events for the assertions
  logic in_win;
  cls_t cls;
  act_t act_next;
  act_t act_q;
  logic vld_q;
  logic strict_rd_hit_byp;

  l2ap_classify #(
    .AW(AW), .WIN_TOP(WIN_TOP), .PW(PW), .CBIT(CBIT), .BBIT(BBIT)
  ) u_cls (
    .addr  (addr_i),
    .prot  (prot_i),
    .en    (prot_en_i),
    .in_win(in_win),
    .cls   (cls)
  );

  l2ap_action u_act (
    .cls(cls),
    .wr (wr_i),
    .hit(hit_i),
    .byp(rd_bypass_i),
    .act(act_next)
  );

  assign strict_rd_hit_byp = req_i && (cls == CLS_STRICT) && !wr_i && hit_i && rd_bypass_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      act_q <= '0;
    end else begin
      vld_q <= req_i;
      act_q <= req_i ? act_next : '0;
    end
  end

  assign vld_o       = vld_q;
  assign use_cache_o = act_q.arr;
  assign use_mem_o   = act_q.mem;
  assign alloc_o     = act_q.alloc;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o);  // R9
  AST_NO_VALID_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !vld_o);  // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> !(use_cache_o || use_mem_o || alloc_o));  // R9
  AST_OUTSIDE_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !in_win) |=> !alloc_o);  // R3
  AST_BYPASS_TO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    strict_rd_hit_byp |=> (use_mem_o && !use_cache_o && !alloc_o));  // R5
  AST_ALLOC_NOT_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_o |-> !use_cache_o);  // R6
  AST_HIT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && hit_i) |=> !alloc_o);  // R4
  AST_WRITE_MISS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && wr_i && !hit_i) |=> $onehot0({use_cache_o, use_mem_o, alloc_o}) && !use_cache_o);  // R8

endmodule

// File: tb/l2_access_policy_test.sv
module l2_access_policy_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        hit_i = 1'b0;
  logic [3:0]  prot_i = '0;
  logic        prot_en_i = 1'b0;
  logic        rd_bypass_i = 1'b0;
  logic        vld_o, use_cache_o, use_mem_o, alloc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] exp_q = '0;  // {vld, arr, mem, alloc}
  string      exp_tag = "R9";

  always #5 clk = ~clk;

  l2_access_policy uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
    .hit_i(hit_i), .prot_i(prot_i), .prot_en_i(prot_en_i), .rd_bypass_i(rd_bypass_i),
    .vld_o(vld_o), .use_cache_o(use_cache_o), .use_mem_o(use_mem_o), .alloc_o(alloc_o)
  );

  // Behavioural reference: returns {vld, arr, mem, alloc}
  function automatic logic [3:0] model(bit req, bit [31:0] a, bit wr, bit hit,
                                       bit [3:0] p, bit pen, bit byp);
    bit cach, bufd;
    cach = (a[31] == 1'b0);
    if (pen && !p[3]) cach = 0;
    bufd = pen && p[2];
    if (!req) return 4'b0000;
    if (!wr && hit) begin
      if (!cach && !bufd && byp) return 4'b1010;
      return 4'b1100;
    end
    if (!wr) return cach ? 4'b1011 : 4'b1010;
    if (hit) return (!cach && !bufd) ? 4'b1110 : 4'b1100;
    return cach ? 4'b1001 : 4'b1010;
  endfunction

  function automatic string tag_of(bit req, bit wr, bit hit, bit pen);
    string t, c;
    if (!req) return "R9";
    if (!wr) t = hit ? "R4 R5" : "R6";
    else     t = hit ? "R7" : "R8";
    c = pen ? "R3" : "R1 R2";
    return {t, " ", c, " R9"};
  endfunction

  task automatic check_now();
    logic [3:0] got;
    got = {vld_o, use_cache_o, use_mem_o, alloc_o};
    checks++;
    if (got !== exp_q) begin
      failures++;
      $display("FAIL %s: got vld/arr/mem/alloc=%b expected %b", exp_tag, got, exp_q);
    end
  endtask

  task automatic step(bit req, bit [31:0] a, bit wr, bit hit, bit [3:0] p, bit pen, bit byp);
    @(negedge clk);
    check_now();
    req_i = req; addr_i = a; wr_i = wr; hit_i = hit;
    prot_i = p; prot_en_i = pen; rd_bypass_i = byp;
    exp_q = model(req, a, wr, hit, p, pen, byp);
    exp_tag = tag_of(req, wr, hit, pen);
  endtask

  initial begin
    logic [31:0] addrs [4];
    int n;
    addrs[0] = 32'h0000_0000; addrs[1] = 32'h7FFF_FFFF;
    addrs[2] = 32'h8000_0000; addrs[3] = 32'hFFFF_FFFF;
    // R10: reset state, with a request pending on the inputs
    req_i = 1'b1; wr_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if ({vld_o, use_cache_o, use_mem_o, alloc_o} !== 4'b0000) begin
        failures++;
        $display("FAIL R10: got %b expected 0000", {vld_o, use_cache_o, use_mem_o, alloc_o});
      end
    end
    req_i = 1'b0; wr_i = 1'b0;
    rst_n = 1'b1;
    exp_q = '0; exp_tag = "R9";
    n = 0;
    for (int ai = 0; ai < 4; ai++)
      for (int p = 0; p < 16; p++)
        for (int k = 0; k < 16; k++) begin
          step(1'b1, addrs[ai], k[0], k[1], p[3:0], k[2], k[3]);
          n++;
          if (n % 5 == 0) step(1'b0, addrs[ai], k[1], k[0], p[3:0], k[2], k[3]);
        end
    step(1'b0, '0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule